// File: doc/BRIEF.md
# Programmable Reversible Gate Cascade

This block pushes an N-bit word through a chain of multiple-control Toffoli gates. The gate list is loaded at run time. Each gate descriptor holds a control mask, the index of one target line and an enable bit. A gate flips its target line when every line named in its mask is 1. It leaves every other line unchanged. A gate whose mask is empty acts as a plain inverter on its target. A disabled gate passes the word through untouched.

The chain is pipelined with one register per gate position, so one word can enter on every clock cycle. A valid flag travels with each word. A direction input selects the gate order. In forward order the gates apply from position 0 upward. In reverse order they apply from the last position down to position 0. Every gate is its own inverse and the cascade is a bijection, so running its output back through in reverse order returns the original word. The direction may change only when the pipeline is empty or right after a flush. The flush input discards everything in flight.

A descriptor write is refused when its target line also appears in its own control mask, or when its target index or position index is out of range. A refused write leaves the stored gate list unchanged and raises an error flag for one cycle.

Top module: `toffoli_cascade`

## Requirements
- R1: In an enabled gate, the target line is inverted exactly when all lines set in the control mask are 1, and all other lines pass unchanged. Line i is bit i of the data word.
- R2: An enabled gate with an all-zero control mask always inverts its target line.
- R3: A gate position whose enable bit is 0 passes the word unchanged.
- R4: With dir_rev = 0, gates apply in ascending position order, from 0 to STAGES-1.
- R5: With dir_rev = 1, gates apply in descending position order. Feeding a forward result back in this mode returns the original word, for every input.
- R6: A word accepted with in_valid = 1 appears on out_data with out_valid = 1 exactly STAGES cycles later. Words leave in order, and gaps between inputs are kept.
- R7: A descriptor write is refused when bit cfg_tgt of cfg_ctrl is 1, or when cfg_tgt >= N, or when cfg_idx >= STAGES. A refused write leaves the gate list unchanged, and cfg_err is 1 in the cycle after the write. An accepted write gives cfg_err = 0.
- R8: A flush removes every word in flight, together with any word offered in the same cycle. No out_valid follows from them.
- R9: After reset, out_valid and out_data are 0 and every gate position is disabled.
- R10: Forward outputs over all 2^N inputs are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | clog2(STAGES) | Gate position to write |
| cfg_ctrl | input | N | Control mask |
| cfg_tgt | input | clog2(N) | Target line index |
| cfg_en | input | 1 | Gate enable |
| cfg_err | output | 1 | Previous write was refused |
| dir_rev | input | 1 | 0: ascending gate order, 1: descending |
| flush | input | 1 | Discard all words in flight |
| in_valid | input | 1 | Input word valid |
| in_data | input | N | Input word |
| out_valid | output | 1 | Output word valid |
| out_data | output | N | Output word |

## Verification
A flush and an arriving word can meet in the same cycle. A flush can also coincide with words still travelling down the pipeline. The bench issues several words, pulses flush together with in_valid carrying a fresh word, and then watches out_valid for longer than the pipeline depth, where any pulse is a failure. It then streams a new word and expects it to come out unaffected. The direction is switched only once the pipeline is empty, and all 256 forward results are fed back in reverse order to recover their inputs.

// File: rtl/toffoli_cascade.sv
module toffoli_cascade #(
  parameter int N      = 8,
  parameter int STAGES = 16,
  localparam int TW    = (N > 1) ? $clog2(N) : 1,
  localparam int SW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_idx,
  input  logic [N-1:0]  cfg_ctrl,
  input  logic [TW-1:0] cfg_tgt,
  input  logic          cfg_en,
  output logic          cfg_err,
  input  logic          dir_rev,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [N-1:0]  in_data,
  output logic          out_valid,
  output logic [N-1:0]  out_data
);

  localparam logic [TW:0] NLIM = N[TW:0];
  localparam logic [SW:0] SLIM = STAGES[SW:0];

  logic [N-1:0]  g_ctl [STAGES];
  logic [TW-1:0] g_tgt [STAGES];
  logic [STAGES-1:0] g_en;

  logic [N-1:0] dq [STAGES];
  logic [STAGES-1:0] vq;

  logic [N-1:0] tgt_bit;
  logic refuse;

  assign tgt_bit = N'(1) << cfg_tgt;
  assign refuse  = ({1'b0, cfg_tgt} >= NLIM) || ({1'b0, cfg_idx} >= SLIM) ||
                   ((cfg_ctrl & tgt_bit) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
      g_en    <= '0;
      for (int i = 0; i < STAGES; i++) begin
        g_ctl[i] <= '0;
        g_tgt[i] <= '0;
      end
    end else begin
      cfg_err <= cfg_we && refuse;
      if (cfg_we && !refuse) begin
        g_ctl[cfg_idx] <= cfg_ctrl;
        g_tgt[cfg_idx] <= cfg_tgt;
        g_en[cfg_idx]  <= cfg_en;
      end
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int FWD = k;
    localparam int REV = STAGES - 1 - k;

    logic [N-1:0]  src, mask, nxt;
    logic [TW-1:0] tg;
    logic          en, hit, vin;

    if (k == 0) begin : g_head
      assign src = in_data;
      assign vin = in_valid;
    end else begin : g_body
      assign src = dq[k-1];
      assign vin = vq[k-1];
    end

    assign mask = dir_rev ? g_ctl[REV] : g_ctl[FWD];
    assign tg   = dir_rev ? g_tgt[REV] : g_tgt[FWD];
    assign en   = dir_rev ? g_en[REV]  : g_en[FWD];
    assign hit  = en && ((src & mask) == mask);
    assign nxt  = src ^ (hit ? (N'(1) << tg) : '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vq[k] <= 1'b0;
        dq[k] <= '0;
      end else begin
        vq[k] <= vin && !flush;
        dq[k] <= nxt;
      end
    end
  end

  assign out_valid = vq[STAGES-1];
  assign out_data  = dq[STAGES-1];

endmodule

// File: rtl/toffoli_cascade_chk.sv
module toffoli_cascade_chk #(
  parameter int N      = 8,
  parameter int STAGES = 16,
  localparam int TW    = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [N-1:0]      cfg_ctrl,
  input logic [TW-1:0]     cfg_tgt,
  input logic              cfg_err,
  input logic              dir_rev,
  input logic              flush,
  input logic              in_valid,
  input logic [STAGES-1:0] vq,
  input logic              out_valid
);

  logic self_ctl;
  assign self_ctl = ((cfg_ctrl >> cfg_tgt) & N'(1)) != '0;

  a_r7_refuse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && self_ctl) |=> cfg_err);

  a_r7_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !cfg_err);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vq == '0) && !out_valid);

  a_r6_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (vq[0] == $past(in_valid)));

  a_r6_shift_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (vq[STAGES-1:1] == $past(vq[STAGES-2:0])));

  a_r5_dir_change_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rev != $past(dir_rev)) |-> ($past(flush) || ($past(vq) == '0)));

endmodule

bind toffoli_cascade toffoli_cascade_chk #(.N(N), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
  .cfg_tgt(cfg_tgt), .cfg_err(cfg_err), .dir_rev(dir_rev), .flush(flush),
  .in_valid(in_valid), .vq(vq), .out_valid(out_valid)
);

// File: tb/toffoli_cascade_tb.sv
module toffoli_cascade_tb;
  localparam int N = 8;
  localparam int STAGES = 16;

  // high byte: input word, low byte: forward result of the table cascade
  localparam logic [15:0] VEC [8] = '{16'h0001, 16'h0100, 16'h0287, 16'h0302,
                                      16'h0485, 16'h0603, 16'hFF7E, 16'h8081};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, dir_rev = 1'b0, flush = 1'b0, in_valid = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_ctrl = '0, in_data = '0;
  logic [2:0] cfg_tgt = '0;
  logic cfg_err, out_valid;
  logic [7:0] out_data;

  int n_run = 0, n_fail = 0;
  logic [7:0] stim [256], expv [256], got [256];
  int issue_c [256];
  logic [7:0] m_ctl [STAGES];
  logic [2:0] m_tgt [STAGES];
  logic       m_en  [STAGES];
  logic       last_err;

  toffoli_cascade #(.N(N), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ctrl(cfg_ctrl), .cfg_tgt(cfg_tgt), .cfg_en(cfg_en), .cfg_err(cfg_err),
    .dir_rev(dir_rev), .flush(flush), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] model(input logic [7:0] x, input bit rev);
    logic [7:0] v = x;
    for (int s = 0; s < STAGES; s++) begin
      int p = rev ? STAGES - 1 - s : s;
      if (m_en[p] && ((v & m_ctl[p]) == m_ctl[p])) v[m_tgt[p]] = ~v[m_tgt[p]];
    end
    return v;
  endfunction

  task automatic wr(input int idx, input logic [7:0] ctl, input int tg, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_ctrl = ctl; cfg_tgt = 3'(tg); cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
    last_err = cfg_err;
    if (!ctl[tg]) begin
      m_ctl[idx] = ctl; m_tgt[idx] = 3'(tg); m_en[idx] = en;
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < STAGES; i++) wr(i, 8'h00, 0, 1'b0);
  endtask

  task automatic load_table();
    clear_all();
    wr(0, 8'h00, 0, 1'b1);
    wr(5, 8'h03, 2, 1'b1);
    wr(15, 8'h04, 7, 1'b1);
  endtask

  task automatic run_stream(input int cnt, input int gap, input string tag);
    int ic = 0, oc = 0;
    for (int c = 0; c < cnt * gap + STAGES + 4; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (oc < cnt) begin
          got[oc] = out_data;
          check(out_data == expv[oc], tag, out_data, expv[oc]);
          check(c == issue_c[oc] + STAGES, "R6 latency", c - issue_c[oc], STAGES);
        end else check(1'b0, "R6 extra output", oc, cnt);
        oc++;
      end
      if (ic < cnt && (c % gap) == 0) begin
        in_valid = 1'b1; in_data = stim[ic]; issue_c[ic] = c; ic++;
      end else in_valid = 1'b0;
    end
    check(oc == cnt, "R6 output count", oc, cnt);
  endtask

  initial begin
    bit seen [256];
    int dup;
    for (int i = 0; i < STAGES; i++) begin m_ctl[i] = '0; m_tgt[i] = '0; m_en[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    check(out_data == 8'h00, "R9 reset out_data", out_data, 0);
    rst_n = 1'b1;

    // R9: all positions disabled after reset, identity mapping
    stim[0] = 8'hA5; expv[0] = 8'hA5;
    run_stream(1, 1, "R9 reset gates disabled");

    // R1 R2 R4: table cascade, forward order, back-to-back
    load_table();
    for (int i = 0; i < 8; i++) begin stim[i] = VEC[i][15:8]; expv[i] = VEC[i][7:0]; end
    run_stream(8, 1, "R1 R2 R4 table forward");
    // R6: bubbles between words
    run_stream(8, 3, "R6 table with gaps");

    // R5: reverse order recovers the inputs
    dir_rev = 1'b1;
    for (int i = 0; i < 8; i++) begin stim[i] = VEC[i][7:0]; expv[i] = VEC[i][15:8]; end
    run_stream(8, 1, "R5 table reverse");
    dir_rev = 1'b0;

    // R7: target inside own mask refused, gate list unchanged
    wr(5, 8'h04, 2, 1'b1);
    check(last_err == 1'b1, "R7 refuse flag", last_err, 1);
    stim[0] = 8'h02; expv[0] = 8'h87;
    run_stream(1, 1, "R7 list unchanged");
    wr(3, 8'h00, 1, 1'b0);
    check(last_err == 1'b0, "R7 accept flag", last_err, 0);

    // R3: disable the last gate
    wr(15, 8'h04, 7, 1'b0);
    stim[0] = 8'h02; expv[0] = 8'h07;
    stim[1] = 8'hFF; expv[1] = 8'hFE;
    run_stream(2, 1, "R3 disabled passes");
    // R2: empty mask inverts its target regardless of other lines
    stim[0] = 8'h00; expv[0] = 8'h01;
    run_stream(1, 1, "R2 empty mask");

    // R8: flush together with a new word, plus words in flight
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(i);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_data = 8'h55;
    @(negedge clk); flush = 1'b0; in_valid = 1'b0;
    begin
      int seen_v = 0;
      for (int c = 0; c < STAGES + 6; c++) begin
        @(negedge clk);
        if (out_valid) seen_v++;
      end
      check(seen_v == 0, "R8 flush drops all", seen_v, 0);
    end
    stim[0] = 8'h40; expv[0] = 8'h41;
    run_stream(1, 1, "R8 after flush");

    // R10 R5: dense cascade, all inputs forward then reverse
    for (int k = 0; k < STAGES; k++) begin
      int tg = (k * 3 + 1) % 8;
      logic [7:0] c = 8'(k * 37 + 11);
      c[tg] = 1'b0;
      if (k == 4) c = 8'h00;
      wr(k, c, tg, k != 9);
    end
    for (int i = 0; i < 256; i++) begin stim[i] = 8'(i); expv[i] = model(8'(i), 1'b0); end
    run_stream(256, 1, "R4 exhaustive forward");
    dup = 0;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    for (int i = 0; i < 256; i++) begin
      if (seen[got[i]]) dup++;
      seen[got[i]] = 1'b1;
    end
    check(dup == 0, "R10 distinct outputs", dup, 0);
    dir_rev = 1'b1;
    for (int i = 0; i < 256; i++) begin stim[i] = got[i]; expv[i] = 8'(i); end
    run_stream(256, 1, "R5 exhaustive round trip");
    dir_rev = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule